// File: doc/BRIEF.md
# Staged Channel-Select Address Unhasher

This block recovers the true channel-select bits of a normalized physical address when the memory system has spread addresses across channels with an XOR hash. Each select bit was scrambled with a few higher address bits, one for each of three hash granularities: 64 KiB, 2 MiB and 1 GiB. Each granularity has its own enable input. The block removes that scrambling in up to four ordered stages. Each stage owns one select bit and sees the address as left by the stages before it.

The number of stages that run follows the total interleaved channel count across all sockets: one stage for 2 channels and four stages for 16. When exactly one socket takes part, the first stage also folds in a low-order term. A caller presents an address together with its controls on a valid strobe. The corrected address appears one clock later with its own valid flag. A channel count that is not a supported power of two raises an error flag, and the address then passes through untouched.

Top module: `chu_unhash`

## Requirements
- R1: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high. After reset, `out_valid`, `out_err` and `out_addr` are all 0.
- R2: Every address bit other than bits 8, 12, 13 and 14 reaches `out_addr` unchanged.
- R3: Stage 0 replaces bit 8 with bit 8 XOR (bit16 AND `en_64k`) XOR (bit21 AND `en_2m`) XOR (bit30 AND `en_1g`). This stage runs for every supported channel count.
- R4: When `one_socket` is 1, stage 0 also XORs in address bit 14, taken as it was at the input, before any later stage changes it.
- R5: When `chan_total` is 4 or more, stage 1 replaces bit 12 with bit 12 XOR the gated bits 17, 22 and 31.
- R6: When `chan_total` is 8 or more, stage 2 replaces bit 13 with bit 13 XOR the gated bits 18, 23 and 32.
- R7: When `chan_total` is 16, stage 3 replaces bit 14 with bit 14 XOR the gated bits 19, 24 and 33.
- R8: `chan_total` is a plain binary count. Any value other than 2, 4, 8 or 16 sets `out_err` to 1 and passes `in_addr` through unchanged. A supported value clears `out_err`.
- R9: While `in_valid` is low, `out_addr` and `out_err` keep their previous values.
- R10: With all three enables low and `one_socket` low, the address passes through unchanged for any supported channel count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Capture strobe for the address and controls |
| in_addr | input | 48 | Normalized, still-hashed address |
| en_64k | input | 1 | Enable for the 64 KiB hash term |
| en_2m | input | 1 | Enable for the 2 MiB hash term |
| en_1g | input | 1 | Enable for the 1 GiB hash term |
| chan_total | input | 5 | Total interleaved channel count across sockets |
| one_socket | input | 1 | High when exactly one socket is interleaved |
| out_valid | output | 1 | Result valid, one cycle after capture |
| out_addr | output | 48 | Address with select bits unhashed |
| out_err | output | 1 | Unsupported channel count seen at capture |

## Verification
Two things act on bit 14 in the same pass. The single-socket term in stage 0 reads it, and stage 3 rewrites it when 16 channels are active. The bench provokes this collision by presenting an address with bits 14 and 19 set, `en_64k` high, `one_socket` high and a count of 16. It expects bit 8 to flip because of the original bit 14, while bit 14 itself is cleared by bit 19. A design that ran the stages in the wrong order, or that fed stage 0 the updated bit, would leave bit 8 clear and is reported.

// File: rtl/chu_pkg.sv
package chu_pkg;
    localparam int ADDR_W     = 48;
    localparam int NUM_STAGES = 4;
    localparam int CNT_W      = NUM_STAGES + 1;
    localparam int NUM_SIZES  = 3;
    localparam int SOCK_POS   = 14;

    // Target bit of a stage: the first stage sits apart, later ones are contiguous.
    function automatic int tgt_pos(input int stage);
        return (stage == 0) ? 8 : 11 + stage;
    endfunction

    // Tap position per stage and granularity (0: 64K, 1: 2M, 2: 1G).
    function automatic int tap_pos(input int stage, input int size);
        int base;
        case (size)
            0:       base = 16;
            1:       base = 21;
            default: base = 30;
        endcase
        return base + stage;
    endfunction

    function automatic logic [ADDR_W-1:0] sel_mask();
        logic [ADDR_W-1:0] m;
        m = '0;
        for (int s = 0; s < NUM_STAGES; s++) m[tgt_pos(s)] = 1'b1;
        return m;
    endfunction

    typedef struct packed {
        logic              valid;
        logic              err;
        logic [ADDR_W-1:0] addr;
    } out_st_t;
endpackage

// File: rtl/chu_count_decode.sv
module chu_count_decode #(
    parameter int NUM_STAGES = chu_pkg::NUM_STAGES,
    parameter int CNT_W      = chu_pkg::CNT_W
) (
    input  logic [CNT_W-1:0]      chan_total,
    output logic [NUM_STAGES-1:0] stage_en,
    output logic                  count_bad
);
    logic [NUM_STAGES-1:0] hit;

    for (genvar s = 0; s < NUM_STAGES; s++) begin : g_hit
        localparam logic [CNT_W-1:0] STEP = CNT_W'(2 << s);
        assign hit[s] = (chan_total == STEP);
    end

    for (genvar s = 0; s < NUM_STAGES; s++) begin : g_en
        localparam logic [CNT_W-1:0] LIMIT = CNT_W'(2 << s);
        assign stage_en[s] = (|hit) && (chan_total >= LIMIT);
    end

    assign count_bad = ~(|hit);
endmodule

// File: rtl/chu_stage.sv
module chu_stage #(
    parameter int STAGE  = 0,
    parameter int ADDR_W = chu_pkg::ADDR_W
) (
    input  logic [ADDR_W-1:0]            addr_i,
    input  logic [chu_pkg::NUM_SIZES-1:0] size_en,
    input  logic                         active,
    input  logic                         one_socket,
    output logic [ADDR_W-1:0]            addr_o
);
    localparam int TGT = chu_pkg::tgt_pos(STAGE);
    localparam int T0  = chu_pkg::tap_pos(STAGE, 0);
    localparam int T1  = chu_pkg::tap_pos(STAGE, 1);
    localparam int T2  = chu_pkg::tap_pos(STAGE, 2);
    localparam logic FIRST = (STAGE == 0);

    logic flip;

    always_comb begin
        flip = (size_en[0] & addr_i[T0])
             ^ (size_en[1] & addr_i[T1])
             ^ (size_en[2] & addr_i[T2])
             ^ (FIRST & one_socket & addr_i[chu_pkg::SOCK_POS]);
        addr_o      = addr_i;
        addr_o[TGT] = addr_i[TGT] ^ (flip & active);
    end
endmodule

// File: rtl/chu_unhash.sv
module chu_unhash #(
    parameter int ADDR_W     = chu_pkg::ADDR_W,
    parameter int NUM_STAGES = chu_pkg::NUM_STAGES,
    parameter int CNT_W      = chu_pkg::CNT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic              en_64k,
    input  logic              en_2m,
    input  logic              en_1g,
    input  logic [CNT_W-1:0]  chan_total,
    input  logic              one_socket,
    output logic              out_valid,
    output logic [ADDR_W-1:0] out_addr,
    output logic              out_err
);
    import chu_pkg::*;

    localparam logic [ADDR_W-1:0] SEL_MASK = sel_mask();

    logic [NUM_STAGES-1:0]  stage_en;
    logic                   count_bad;
    logic [NUM_SIZES-1:0]   size_en;
    logic [ADDR_W-1:0]      chain [NUM_STAGES+1];
    out_st_t                st_d, st_q;

    assign size_en = {en_1g, en_2m, en_64k};

    chu_count_decode #(.NUM_STAGES(NUM_STAGES), .CNT_W(CNT_W)) u_dec (
        .chan_total (chan_total),
        .stage_en   (stage_en),
        .count_bad  (count_bad)
    );

    assign chain[0] = in_addr;

    for (genvar s = 0; s < NUM_STAGES; s++) begin : g_stage
        chu_stage #(.STAGE(s), .ADDR_W(ADDR_W)) u_stage (
            .addr_i     (chain[s]),
            .size_en    (size_en),
            .active     (stage_en[s]),
            .one_socket (one_socket),
            .addr_o     (chain[s+1])
        );
    end

    always_comb begin
        st_d       = st_q;
        st_d.valid = in_valid;
        if (in_valid) begin
            st_d.err  = count_bad;
            st_d.addr = count_bad ? in_addr : chain[NUM_STAGES];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.valid;
    assign out_addr  = st_q.addr;
    assign out_err   = st_q.err;

    a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    a_r1_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    a_r2_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> ((out_addr & ~SEL_MASK) == ($past(in_addr) & ~SEL_MASK)));
    a_r8_bad_count: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && chan_total != CNT_W'(2) && chan_total != CNT_W'(4)
                  && chan_total != CNT_W'(8) && chan_total != CNT_W'(16))
        |=> (out_err && out_addr == $past(in_addr)));
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_addr) && $stable(out_err)));
    a_r5_two_chan_upper: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && chan_total == CNT_W'(2)) |=> (out_addr[14:12] == $past(in_addr[14:12])));
endmodule

// File: tb/chu_unhash_test.sv
module chu_unhash_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [47:0] in_addr = '0;
    logic        en_64k = 1'b0, en_2m = 1'b0, en_1g = 1'b0;
    logic [4:0]  chan_total = 5'd2;
    logic        one_socket = 1'b0;
    logic        out_valid;
    logic [47:0] out_addr;
    logic        out_err;

    int checks = 0;
    int failures = 0;
    logic [63:0] seed = 64'h9E3779B97F4A7C15;

    always #4 clk = ~clk;

    chu_unhash uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_addr(in_addr),
        .en_64k(en_64k), .en_2m(en_2m), .en_1g(en_1g), .chan_total(chan_total),
        .one_socket(one_socket), .out_valid(out_valid), .out_addr(out_addr), .out_err(out_err)
    );

    task automatic chk(input string req, input logic [47:0] act, input logic [47:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Model built from the requirement text.
    function automatic logic [48:0] model(input logic [47:0] a, input logic e0, input logic e1,
                                          input logic e2, input logic [4:0] n, input logic os);
        logic [47:0] r;
        logic orig14;
        r = a;
        if (n != 5'd2 && n != 5'd4 && n != 5'd8 && n != 5'd16) return {1'b1, a};
        orig14 = a[14];
        r[8] = a[8] ^ (a[16] & e0) ^ (a[21] & e1) ^ (a[30] & e2) ^ (orig14 & os);
        if (n >= 5'd4)  r[12] = r[12] ^ (r[17] & e0) ^ (r[22] & e1) ^ (r[31] & e2);
        if (n >= 5'd8)  r[13] = r[13] ^ (r[18] & e0) ^ (r[23] & e1) ^ (r[32] & e2);
        if (n == 5'd16) r[14] = r[14] ^ (r[19] & e0) ^ (r[24] & e1) ^ (r[33] & e2);
        return {1'b0, r};
    endfunction

    task automatic apply(input logic [47:0] a, input logic e0, input logic e1, input logic e2,
                         input logic [4:0] n, input logic os);
        @(negedge clk);
        in_addr = a; en_64k = e0; en_2m = e1; en_1g = e2; chan_total = n; one_socket = os;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic run_vs_model(input string req, input logic [47:0] a, input logic e0,
                                input logic e1, input logic e2, input logic [4:0] n, input logic os);
        logic [48:0] exp;
        exp = model(a, e0, e1, e2, n, os);
        apply(a, e0, e1, e2, n, os);
        chk(req, out_addr, exp[47:0]);
        chk(req, {47'd0, out_err}, {47'd0, exp[48]});
        chk({req, " R1 valid"}, {47'd0, out_valid}, 48'd1);
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 reset addr", out_addr, 48'd0);
        chk("R1 reset valid", {47'd0, out_valid}, 48'd0);
        chk("R1 reset err", {47'd0, out_err}, 48'd0);
        rst_n = 1'b1;
    endtask

    task automatic t_stage0;
        apply(48'h1_0000, 1, 0, 0, 5'd2, 0);
        chk("R3 bit16 64k", out_addr, 48'h1_0100);
        apply(48'h20_0000, 0, 1, 0, 5'd2, 0);
        chk("R3 bit21 2m", out_addr, 48'h20_0100);
        apply(48'h4000_0100, 0, 0, 1, 5'd2, 0);
        chk("R3 bit30 1g clears", out_addr, 48'h4000_0000);
        apply(48'h1_0000, 0, 1, 1, 5'd2, 0);
        chk("R3 disabled size", out_addr, 48'h1_0000);
    endtask

    task automatic t_socket;
        apply(48'h4000, 0, 0, 0, 5'd2, 1);
        chk("R4 socket term", out_addr, 48'h4100);
        apply(48'h4000, 0, 0, 0, 5'd2, 0);
        chk("R4 socket off", out_addr, 48'h4000);
    endtask

    task automatic t_depth;
        logic [47:0] a;
        a = 48'h3_8387_0000 | 48'h0000_0000_0000;
        a = (48'h1 << 17) | (48'h1 << 18) | (48'h1 << 19);
        apply(a, 1, 0, 0, 5'd2, 0);
        chk("R5 two chan no stage1", out_addr, a);
        apply(a, 1, 0, 0, 5'd4, 0);
        chk("R5 four chan bit12", out_addr, a | (48'h1 << 12));
        apply(a, 1, 0, 0, 5'd8, 0);
        chk("R6 eight chan bit13", out_addr, a | (48'h3 << 12));
        apply(a, 1, 0, 0, 5'd16, 0);
        chk("R7 sixteen chan bit14", out_addr, a | (48'h7 << 12));
        a = (48'h1 << 31) | (48'h1 << 32) | (48'h1 << 33);
        apply(a, 0, 0, 1, 5'd16, 0);
        chk("R7 1g taps all stages", out_addr, a | (48'h7 << 12));
    endtask

    task automatic t_order;
        apply((48'h1 << 14) | (48'h1 << 19), 1, 0, 0, 5'd16, 1);
        chk("R4 R7 bit14 order", out_addr, (48'h1 << 19) | (48'h1 << 8));
    endtask

    task automatic t_bad;
        apply(48'hABCD_1234_5678, 1, 1, 1, 5'd3, 1);
        chk("R8 bad count addr", out_addr, 48'hABCD_1234_5678);
        chk("R8 bad count err", {47'd0, out_err}, 48'd1);
        apply(48'hFFFF_FFFF_FFFF, 1, 1, 1, 5'd0, 0);
        chk("R8 zero count", out_addr, 48'hFFFF_FFFF_FFFF);
        apply(48'h0, 1, 1, 1, 5'd8, 0);
        chk("R8 err cleared", {47'd0, out_err}, 48'd0);
    endtask

    task automatic t_hold;
        logic [47:0] prev;
        apply(48'h5555_5555_5555, 1, 1, 1, 5'd31, 0);
        prev = out_addr;
        @(negedge clk);
        in_addr = 48'h1234_0000_0000; chan_total = 5'd4;
        @(negedge clk);
        @(negedge clk);
        chk("R9 hold addr", out_addr, prev);
        chk("R9 hold err", {47'd0, out_err}, 48'd1);
        chk("R1 idle valid", {47'd0, out_valid}, 48'd0);
    endtask

    task automatic t_noenable;
        apply(48'hFFFF_FFFF_FFFF, 0, 0, 0, 5'd16, 0);
        chk("R10 all off 16", out_addr, 48'hFFFF_FFFF_FFFF);
        apply(48'h8421_8421_8421, 0, 0, 0, 5'd4, 0);
        chk("R10 all off 4", out_addr, 48'h8421_8421_8421);
    endtask

    task automatic t_patterns;
        for (int i = 0; i < 200; i++) begin
            logic [4:0] n;
            seed = seed ^ (seed << 13); seed = seed ^ (seed >> 7); seed = seed ^ (seed << 17);
            case (seed[51:50])
                2'd0: n = 5'd2; 2'd1: n = 5'd4; 2'd2: n = 5'd8; default: n = 5'd16;
            endcase
            if (seed[55:52] == 4'hF) n = seed[60:56];
            run_vs_model("R2 R3 R5 R6 R7 pattern", seed[47:0], seed[48], seed[49], seed[61], n, seed[62]);
        end
    endtask

    initial begin
        #(8 * 200000);
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        t_reset();
        t_stage0();
        t_socket();
        t_depth();
        t_order();
        t_bad();
        t_hold();
        t_noenable();
        t_patterns();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule